// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block is a cartridge-side bank mapper. It sits on the write side of an 8-bit CPU bus and turns register writes into bank numbers. An external memory model uses these numbers to place program ROM into four 8 KB CPU windows and pattern memory into eight 1 KB video windows. The block also drives a nametable mirroring code.

A CPU write is taken on a single-cycle strobe. Only address bits 15, 14, 13 and 0 are decoded. A write to the select slot sets three things: the index of the bank register that the next data write will load, the program layout mode and the pattern layout mode. Eight bank registers hold bank numbers. Registers 0 and 1 each name an aligned 2 KB pattern pair. Registers 2 to 5 name single 1 KB pattern banks. Registers 6 and 7 name 8 KB program banks. The two program windows that no register controls are tied to the two highest banks of the ROM, whose size is a parameter counted in 8 KB banks. All bank outputs are combinational functions of the stored registers.

The write path is one stage. The decoder classifies each strobed write into a slot: none, select, data, mirror or other. The register store updates on that clock edge. There is no other sequencing.

Top module: `bank_mapper_regs`

## Requirements
- R1: On synchronous reset, every register clears to zero. Afterwards the program windows read 0, 0, PRG_BANKS-2, PRG_BANKS-1. The pattern windows read 0,1,0,1,0,0,0,0 and `mirror_sel` is 2'b00 (vertical).
- R2: A write is decoded from wr_addr[15:13] and wr_addr[0] only. 100/0 is select, 100/1 is data, 101/0 is mirror. Any other value of bits 12:1 aliases to the same slot.
- R3: A select write stores data bits 2:0 as the target register, bit 6 as the program mode and bit 7 as the pattern mode. Bits 5:3 have no effect.
- R4: A data write loads the targeted bank register with the data byte. For targets 0 and 1, bit 0 is stored as 0.
- R5: Pattern mode 0 gives windows 0..3 = r0, r0|1, r1, r1|1 and windows 4..7 = r2, r3, r4, r5.
- R6: Pattern mode 1 gives windows 0..3 = r2, r3, r4, r5 and windows 4..7 = r0, r0|1, r1, r1|1.
- R7: Program mode 0 gives windows 0..3 = r6, r7, PRG_BANKS-2, PRG_BANKS-1.
- R8: Program mode 1 gives windows 0..3 = PRG_BANKS-2, r7, r6, PRG_BANKS-1.
- R9: A mirror write stores data bit 0. `mirror_sel` is 2'b01 (horizontal) when the stored bit is 1 and 2'b00 (vertical) when it is 0.
- R10: While `four_screen_strap` is 1, `mirror_sel` is 2'b10, whatever the stored bit.
- R11: Writes to slot 101/1, to any slot with bits 15:13 of 110 or 111, and to any address below 0x8000 leave every output unchanged.
- R12: With `wr_stb` low, no address or data changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Single-cycle CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| four_screen_strap | input | 1 | Board strap that forces four-screen mirroring |
| prg_bank_flat | output | 32 | Program window w bank at bits [8w+7:8w] |
| chr_bank_flat | output | 64 | Pattern window w bank at bits [8w+7:8w] |
| mirror_sel | output | 2 | 00 vertical, 01 horizontal, 10 four-screen |

## Verification
A strobed write is registered on the rising edge where the strobe is high. The bank and mirroring outputs follow combinationally from that edge, so their new values are due in the same cycle. The bench drives every write at a falling edge and samples all outputs at the next falling edge, half a period after the registering edge. The strap override takes no clock at all, so the bench samples it one time step after changing the strap. Between a write and its check, the bench also sets a bench-side model of the registers from the requirement text.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int BANK_W      = 8;
    localparam int NUM_REGS    = 8;
    localparam int PRG_WINDOWS = 4;
    localparam int CHR_WINDOWS = 8;
    localparam int TGT_W       = $clog2(NUM_REGS);

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_SELECT,
        SLOT_DATA,
        SLOT_MIRROR,
        SLOT_OTHER
    } slot_e;

    typedef struct packed {
        logic             chr_swap;
        logic             prg_swap;
        logic [TGT_W-1:0] target;
    } select_t;
endpackage

// File: rtl/mapper_wr_decode.sv
module mapper_wr_decode
    import mapper_pkg::*;
(
    input  logic        wr_stb,
    input  logic [15:0] wr_addr,
    output slot_e       slot
);
    logic [3:0] key;
    assign key = {wr_addr[15:13], wr_addr[0]};

    always_comb begin
        slot = SLOT_NONE;
        if (wr_stb) begin
            unique case (key)
                4'b100_0: slot = SLOT_SELECT;
                4'b100_1: slot = SLOT_DATA;
                4'b101_0: slot = SLOT_MIRROR;
                default:  slot = wr_addr[15] ? SLOT_OTHER : SLOT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mapper_reg_store.sv
module mapper_reg_store
    import mapper_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  slot_e                        slot,
    input  logic [BANK_W-1:0]            wr_data,
    output select_t                      sel_q,
    output logic [NUM_REGS*BANK_W-1:0]   regs_flat,
    output logic                         mirror_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            mirror_q <= 1'b0;
        end else begin
            if (slot == SLOT_SELECT) begin
                sel_q.chr_swap <= wr_data[7];
                sel_q.prg_swap <= wr_data[6];
                sel_q.target   <= wr_data[TGT_W-1:0];
            end
            if (slot == SLOT_MIRROR)
                mirror_q <= wr_data[0];
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
        localparam logic [BANK_W-1:0] KEEP = (i < 2) ? {{(BANK_W-1){1'b1}}, 1'b0} : '1;
        logic [BANK_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= '0;
            else if (slot == SLOT_DATA && sel_q.target == TGT_W'(i))
                r_q <= wr_data & KEEP;
        end
        assign regs_flat[i*BANK_W +: BANK_W] = r_q;
    end
endmodule

// File: rtl/mapper_prg_layout.sv
module mapper_prg_layout
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 32
) (
    input  logic                            prg_swap,
    input  logic [BANK_W-1:0]               reg6,
    input  logic [BANK_W-1:0]               reg7,
    output logic [PRG_WINDOWS*BANK_W-1:0]   prg_flat
);
    localparam logic [BANK_W-1:0] LAST_BANK   = BANK_W'(PRG_BANKS - 1);
    localparam logic [BANK_W-1:0] PENULT_BANK = BANK_W'(PRG_BANKS - 2);

    always_comb begin
        if (prg_swap)
            prg_flat = {LAST_BANK, reg6, reg7, PENULT_BANK};
        else
            prg_flat = {LAST_BANK, PENULT_BANK, reg7, reg6};
    end
endmodule

// File: rtl/mapper_chr_layout.sv
module mapper_chr_layout
    import mapper_pkg::*;
(
    input  logic                            chr_swap,
    input  logic [NUM_REGS*BANK_W-1:0]      regs_flat,
    output logic [CHR_WINDOWS*BANK_W-1:0]   chr_flat
);
    localparam int HALF = CHR_WINDOWS / 2;

    logic [BANK_W-1:0] pair_half [HALF];
    logic [BANK_W-1:0] single_half [HALF];

    for (genvar k = 0; k < HALF; k++) begin : g_win
        localparam int PAIR_REG = k / 2;
        logic [BANK_W-1:0] base;
        assign base           = regs_flat[PAIR_REG*BANK_W +: BANK_W];
        assign pair_half[k]   = (k % 2 == 0) ? {base[BANK_W-1:1], 1'b0} : {base[BANK_W-1:1], 1'b1};
        assign single_half[k] = regs_flat[(k+2)*BANK_W +: BANK_W];
        assign chr_flat[k*BANK_W +: BANK_W]        = chr_swap ? single_half[k] : pair_half[k];
        assign chr_flat[(k+HALF)*BANK_W +: BANK_W] = chr_swap ? pair_half[k] : single_half[k];
    end
endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        four_screen_strap,
    output logic [31:0] prg_bank_flat,
    output logic [63:0] chr_bank_flat,
    output logic [1:0]  mirror_sel
);
    slot_e                      slot;
    select_t                    sel_q;
    logic [NUM_REGS*BANK_W-1:0] regs_flat;
    logic                       mirror_q;

    mapper_wr_decode u_decode (
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .slot    (slot)
    );

    mapper_reg_store u_store (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .wr_data   (wr_data),
        .sel_q     (sel_q),
        .regs_flat (regs_flat),
        .mirror_q  (mirror_q)
    );

    mapper_prg_layout #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .prg_swap (sel_q.prg_swap),
        .reg6     (regs_flat[6*BANK_W +: BANK_W]),
        .reg7     (regs_flat[7*BANK_W +: BANK_W]),
        .prg_flat (prg_bank_flat)
    );

    mapper_chr_layout u_chr (
        .chr_swap  (sel_q.chr_swap),
        .regs_flat (regs_flat),
        .chr_flat  (chr_bank_flat)
    );

    always_comb begin
        if (four_screen_strap)
            mirror_sel = 2'b10;
        else
            mirror_sel = {1'b0, mirror_q};
    end
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int PRG_BANKS = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_stb,
    input logic [15:0] wr_addr,
    input logic        four_screen_strap,
    input logic [31:0] prg_bank_flat,
    input logic [63:0] chr_bank_flat,
    input logic [1:0]  mirror_sel
);
    localparam logic [7:0] LAST_BANK   = 8'(PRG_BANKS - 1);
    localparam logic [7:0] PENULT_BANK = 8'(PRG_BANKS - 2);

    assert_prg_last_R7: assert property (@(posedge clk) disable iff (rst)
        prg_bank_flat[31:24] == LAST_BANK);

    assert_prg_penult_R8: assert property (@(posedge clk) disable iff (rst)
        (prg_bank_flat[7:0] == PENULT_BANK) || (prg_bank_flat[23:16] == PENULT_BANK));

    assert_strap_override_R10: assert property (@(posedge clk) disable iff (rst)
        four_screen_strap |-> mirror_sel == 2'b10);

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(prg_bank_flat) && $stable(chr_bank_flat)));

    assert_low_addr_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_addr[15]) |=> ($stable(prg_bank_flat) && $stable(chr_bank_flat)));

    assert_pair_odd_R5: assert property (@(posedge clk) disable iff (rst)
        (chr_bank_flat[15:8] == (chr_bank_flat[7:0] | 8'h01)) ||
        (chr_bank_flat[47:40] == (chr_bank_flat[39:32] | 8'h01)));
endmodule

bind bank_mapper_regs mapper_checker #(.PRG_BANKS(PRG_BANKS)) chk_i (
    .clk               (clk),
    .rst               (rst),
    .wr_stb            (wr_stb),
    .wr_addr           (wr_addr),
    .four_screen_strap (four_screen_strap),
    .prg_bank_flat     (prg_bank_flat),
    .chr_bank_flat     (chr_bank_flat),
    .mirror_sel        (mirror_sel)
);

// File: tb/bank_mapper_regs_tb_top.sv
module bank_mapper_regs_tb_top;
    localparam int NB = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        strap = 1'b0;
    logic [31:0] prg_bank_flat;
    logic [63:0] chr_bank_flat;
    logic [1:0]  mirror_sel;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_reg [8];
    logic [2:0] m_tgt;
    logic       m_prg_mode, m_chr_mode, m_mirror;

    always #5 clk = ~clk;

    bank_mapper_regs #(.PRG_BANKS(NB)) dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .four_screen_strap(strap), .prg_bank_flat(prg_bank_flat),
        .chr_bank_flat(chr_bank_flat), .mirror_sel(mirror_sel)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_tgt = 3'd0; m_prg_mode = 1'b0; m_chr_mode = 1'b0; m_mirror = 1'b0;
    endtask

    // Model built from R2, R3, R4, R9, R11 text
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15:13] == 3'b100 && !a[0]) begin
            m_tgt = d[2:0]; m_prg_mode = d[6]; m_chr_mode = d[7];
        end else if (a[15:13] == 3'b100 && a[0]) begin
            m_reg[m_tgt] = (m_tgt < 3'd2) ? (d & 8'hFE) : d;
        end else if (a[15:13] == 3'b101 && !a[0]) begin
            m_mirror = d[0];
        end
    endtask

    function automatic logic [31:0] exp_prg();
        logic [7:0] l = 8'(NB - 1), p = 8'(NB - 2);
        return m_prg_mode ? {l, m_reg[6], m_reg[7], p} : {l, p, m_reg[7], m_reg[6]};
    endfunction

    function automatic logic [63:0] exp_chr();
        logic [31:0] pairs, singles;
        pairs   = {m_reg[1] | 8'h01, m_reg[1], m_reg[0] | 8'h01, m_reg[0]};
        singles = {m_reg[5], m_reg[4], m_reg[3], m_reg[2]};
        return m_chr_mode ? {pairs, singles} : {singles, pairs};
    endfunction

    function automatic logic [1:0] exp_mirror();
        return strap ? 2'b10 : {1'b0, m_mirror};
    endfunction

    task automatic check_all(input string tag);
        string pt = m_prg_mode ? "R8" : "R7";
        string ct = m_chr_mode ? "R6" : "R5";
        string mt = strap ? "R10" : "R9";
        checks++;
        if (prg_bank_flat !== exp_prg()) begin
            failures++;
            $display("FAIL %s %s prg actual=%h expected=%h", tag, pt, prg_bank_flat, exp_prg());
        end
        checks++;
        if (chr_bank_flat !== exp_chr()) begin
            failures++;
            $display("FAIL %s %s chr actual=%h expected=%h", tag, ct, chr_bank_flat, exp_chr());
        end
        checks++;
        if (mirror_sel !== exp_mirror()) begin
            failures++;
            $display("FAIL %s %s mirror actual=%b expected=%b", tag, mt, mirror_sel, exp_mirror());
        end
    endtask

    // Drive at falling edge, registered at next rising edge, sampled at following falling edge
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic stb);
        wr_addr = a; wr_data = d; wr_stb = stb;
        @(negedge clk);
        wr_stb = 1'b0;
        if (stb) model_write(a, d);
    endtask

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R3 R4 R5..R8: sweep every register over every byte, modes varied, bits 5:3 junk
        for (int r = 0; r < 8; r++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] sel;
                sel = {v[1], v[0], v[5:3], 3'(r)};
                bus_write(16'h8000, sel, 1'b1);
                bus_write(16'h8001, 8'(v), 1'b1);
                check_all("R3/R4 sweep");
            end
        end

        // R2: aliased addresses
        bus_write(16'h9FFE, 8'hC5, 1'b1);
        bus_write(16'h8E73, 8'h3C, 1'b1);
        check_all("R2 alias select/data");
        bus_write(16'hBFF2, 8'h01, 1'b1);
        check_all("R2 alias mirror");

        // R9: mirror values
        for (int v = 0; v < 4; v++) begin
            bus_write(16'hA000, 8'(v * 8'h55), 1'b1);
            check_all("R9 mirror");
        end

        // R11: ignored slots and low addresses
        begin
            logic [15:0] ign [9] = '{16'hA001, 16'hC000, 16'hC001, 16'hE000, 16'hE001,
                                     16'h7FFF, 16'h0000, 16'h6000, 16'hDFFF};
            for (int i = 0; i < 9; i++) begin
                bus_write(ign[i], 8'hFF, 1'b1);
                check_all("R11 ignored slot");
            end
        end

        // R12: no strobe
        bus_write(16'h8000, 8'hC7, 1'b0);
        bus_write(16'h8001, 8'hAA, 1'b0);
        bus_write(16'hA000, 8'h00, 1'b0);
        check_all("R12 no strobe");

        // R10: strap override with both stored values
        strap = 1'b1; #1;
        check_all("R10 strap");
        bus_write(16'hA000, 8'h00, 1'b1);
        check_all("R10 strap held");
        strap = 1'b0; #1;
        check_all("R10 strap released");

        // R1: reset again after traffic
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 re-reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule